// File: doc/BRIEF.md
# Oscillator Settle Timer

This block measures how long a crystal oscillator has been running since it was started or woken from deep sleep. It counts oscillator clock cycles, but only those in which a qualifier input reports that oscillation has actually been detected. Time spent before the oscillator swings is therefore not counted. Elapsed time is reported as an 8-bit sticky thermometer status word. Each bit marks one power-of-two cycle count, and the exponents are a parameter table that defaults to 8, 9, 10, 11, 13, 15, 17 and 18.

A 3-bit select code picks one of the eight thresholds as the settle time. When the qualified count reaches that threshold, the `stable` flag rises and the count and status freeze. A restart pulse clears everything and counting begins again. Clock-switching logic upstream waits on `stable`, and software can read `status` to see how far the oscillator has got.

Top module: `osc_stab_timer`

## Requirements
- R1: A synchronous active-low reset sets `status` to 8'h00 and `stable` to 0.
- R2: Select code k (0..7) maps to threshold 2^STEP_EXP[k], with STEP_EXP ascending. Bit (7-k) of `status` becomes 1 at the clock edge where the qualified count reaches 2^STEP_EXP[k]. Bit 7 therefore sets first and bit 0 last, so `status` is always a thermometer code filled from the MSB.
- R3: A status bit that is 1 stays 1 until the next restart or reset.
- R4: A `restart` pulse clears the count, `status` and `stable` at the next edge. Restart takes priority over counting.
- R5: A cycle with `osc_ok` low is not counted, so `status` does not change in that cycle.
- R6: `stable` rises at the edge where the count reaches the threshold chosen by `sel`. From then on the count and `status` freeze.
- R7: `stable` stays 1 until restart, even if `sel` later picks a higher threshold. If `sel` is lowered to a threshold the count already meets, `stable` rises at the next edge. The count never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Start or wake pulse; clears and restarts the count |
| osc_ok | input | 1 | Oscillation detected; gates counting |
| sel | input | 3 | Settle-time select code |
| status | output | 8 | Sticky thermometer of elapsed thresholds |
| stable | output | 1 | Selected settle time reached |

## Verification
The hardest case to reach is a change of `sel` after part of the count has elapsed. Lowering `sel` must set `stable` without a new count. Raising it afterwards must neither clear `stable` nor resume counting. A directed sequence runs partway with the top code, then drops `sel` during a cycle with `osc_ok` low, then raises it again. To keep the highest thresholds within a short run, the bench uses a small exponent table. Random restarts, gating and occasional mid-run `sel` changes are checked every cycle against a bench model.

// File: rtl/osc_stab_pkg.sv
// Shared constants and types for the oscillator settle timer.
// Assumes: exactly eight thresholds, exponent table strictly ascending.
package osc_stab_pkg;
    localparam int unsigned LEVELS = 8;
    localparam int unsigned SEL_W  = $clog2(LEVELS);
    typedef int unsigned exp_tbl_t [LEVELS];
    localparam exp_tbl_t DEF_EXP = '{8, 9, 10, 11, 13, 15, 17, 18};
    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [LEVELS-1:0] level_vec_t;
endpackage

// File: rtl/osc_qual_counter.sv
// Saturating up-counter of qualified oscillator cycles.
// Assumes: clr has priority; adv_en already includes freeze and qualifier.
// Exposes the next-state value so flag logic updates in the same edge.
module osc_qual_counter #(
    parameter int unsigned CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv_en,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [CNT_W-1:0] cnt_q;

    // Next count: clear, advance unless saturated, or hold.
    always_comb begin
        if (clr)
            cnt_nxt = '0;
        else if (adv_en && (cnt_q != SAT))
            cnt_nxt = cnt_q + 1'b1;
        else
            cnt_nxt = cnt_q;
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/osc_level_flags.sv
// Compares the next count against each power-of-two threshold and keeps
// sticky flags: the thermometer status word and the stable flag.
// Assumes: STEP_EXP ascending, each exponent below CNT_W.
module osc_level_flags
    import osc_stab_pkg::*;
#(
    parameter exp_tbl_t    STEP_EXP = DEF_EXP,
    parameter int unsigned CNT_W    = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  sel_t             sel,
    output level_vec_t       status,
    output logic             stable
);
    level_vec_t reach;

    // One comparator per threshold; select code k drives status bit 7-k.
    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        localparam logic [CNT_W-1:0] LIM = CNT_W'(1) << STEP_EXP[k];
        assign reach[k] = (cnt_nxt >= LIM);
    end

    // Sticky status bits, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            status <= '0;
        end else begin
            for (int k = 0; k < LEVELS; k++)
                status[LEVELS-1-k] <= status[LEVELS-1-k] | reach[k];
        end
    end

    // Stable flag: sets when the selected threshold is met, holds until restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            stable <= 1'b0;
        else
            stable <= stable | reach[sel];
    end
endmodule

// File: rtl/osc_stab_timer.sv
// Top of the oscillator settle timer. Counts cycles qualified by osc_ok
// from a restart, reports elapsed power-of-two thresholds as a sticky
// thermometer word, and freezes once the selected settle time is reached.
// Assumes: clk is the oscillator clock; restart is a one-cycle pulse.
module osc_stab_timer
    import osc_stab_pkg::*;
#(
    parameter exp_tbl_t STEP_EXP = DEF_EXP
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       osc_ok,
    input  logic [2:0] sel,
    output logic [7:0] status,
    output logic       stable
);
    localparam int unsigned CNT_W = STEP_EXP[LEVELS-1] + 1;

    logic [CNT_W-1:0] cnt_nxt;
    logic             adv_en;

    // Advance only on qualified cycles while the settle time is still open.
    assign adv_en = osc_ok & ~stable;

    osc_qual_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .adv_en  (adv_en),
        .cnt_nxt (cnt_nxt)
    );

    osc_level_flags #(.STEP_EXP(STEP_EXP), .CNT_W(CNT_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .cnt_nxt (cnt_nxt),
        .sel     (sel),
        .status  (status),
        .stable  (stable)
    );
endmodule

// File: rtl/osc_stab_timer_chk.sv
// Port-level temporal checks for the oscillator settle timer, bound to the top.
module osc_stab_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       restart,
    input logic       osc_ok,
    input logic [2:0] sel,
    input logic [7:0] status,
    input logic       stable
);
    // R2
    thermo_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~(status >> 1) & 8'h7F) == 8'h00);

    // R3
    sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> ((status & $past(status)) == $past(status)));

    // R4
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (status == 8'h00 && !stable));

    // R5
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_ok && !restart) |=> $stable(status));

    // R6
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stable && !restart) |=> $stable(status));

    // R7
    stable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stable && !restart) |=> stable);
endmodule

bind osc_stab_timer osc_stab_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .osc_ok  (osc_ok),
    .sel     (sel),
    .status  (status),
    .stable  (stable)
);

// File: tb/sim_osc_stab_timer.sv
module sim_osc_stab_timer;
    localparam osc_stab_pkg::exp_tbl_t TB_EXP = '{2, 3, 4, 5, 7, 9, 11, 12};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       osc_ok = 1'b0;
    logic [2:0] sel = 3'd0;
    logic [7:0] status;
    logic       stable;

    int checks = 0;
    int fails  = 0;

    // bench model of the requirements
    int unsigned m_cnt = 0;
    logic [7:0]  m_stat = 8'h00;
    logic        m_stable = 1'b0;

    always #5 clk = ~clk;

    osc_stab_timer #(.STEP_EXP(TB_EXP)) u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart), .osc_ok(osc_ok),
        .sel(sel), .status(status), .stable(stable)
    );

    function automatic int unsigned thr(input int k);
        return 32'd1 << TB_EXP[k];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // apply inputs, advance one edge, update model, compare
    task automatic step(input logic r, input logic ok, input logic [2:0] s);
        string st_tag, sb_tag;
        restart = r; osc_ok = ok; sel = s;
        st_tag = !rst_n ? "R1" : r ? "R4" : !ok ? "R5" : (m_stat != 0) ? "R3" : "R2";
        sb_tag = !rst_n ? "R1" : r ? "R4" : m_stable ? "R7" : "R6";
        @(posedge clk);
        if (!rst_n || r) begin
            m_cnt = 0; m_stat = 8'h00; m_stable = 1'b0;
        end else begin
            if (ok && !m_stable) m_cnt++;
            for (int k = 0; k < 8; k++)
                if (m_cnt >= thr(k)) m_stat[7-k] = 1'b1;
            if (m_cnt >= thr(s)) m_stable = 1'b1;
        end
        #2;
        chk(st_tag, status, m_stat);
        chk(sb_tag, stable, m_stable);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        // R1: reset clears outputs even with counting enabled
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 3'd0);
        chk("R1", {stable, status}, 9'h000);
        rst_n = 1'b1;

        // R6: smallest settle time, then freeze
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 3'd0);
        chk("R6", status, 8'h80);
        chk("R6", stable, 1);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 3'd0);
        chk("R6", status, 8'h80);

        // R4: restart clears
        step(1'b1, 1'b1, 3'd7);
        chk("R4", {stable, status}, 9'h000);

        // R5: no qualified cycles, nothing counted
        for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 3'd7);
        chk("R5", status, 8'h00);

        // R2: full run to the top threshold
        for (int i = 0; i < 4100; i++) step(1'b0, 1'b1, 3'd7);
        chk("R2", status, 8'hFF);
        chk("R2", stable, 1);

        // R7: lower select after partial count, then raise it
        step(1'b1, 1'b0, 3'd7);
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 3'd7);
        chk("R2", status, 8'hF0);
        chk("R7", stable, 0);
        step(1'b0, 1'b0, 3'd2);
        chk("R7", stable, 1);
        for (int i = 0; i < 50; i++) step(1'b0, 1'b1, 3'd7);
        chk("R7", stable, 1);
        chk("R3", status, 8'hF0);

        // random mix
        begin
            logic [2:0] rs = 3'd5;
            for (int i = 0; i < 30000; i++) begin
                logic r;
                r = ($urandom % 2500) == 0;
                if (r || ($urandom % 700) == 0) rs = 3'($urandom % 8);
                step(r, ($urandom % 4) != 0, rs);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule